// File: doc/BRIEF.md
# Decimal Compound-Add Rounding Selector

This block finishes a decimal multiplication. It receives the upper part of a product as two BCD digit vectors whose sum is the true value, together with the guard digit, the round digit and a sticky bit from the discarded tail. A two-output decimal adder forms the plain sum C0 and the sum plus one C1 in a single pass. The final significand is then picked from a small set of candidates:

- C0 or C1 as they are.
- Either of them moved up one digit with the guard digit, or the guard digit plus one, placed below.
- For an overflowing operation, all nines or infinity.

No second addition and no renormalisation after rounding are needed.

The product's significand length is either the sum of the operand lengths or one less. When the top digit of C0 is zero, the result is moved up by one digit. The guard digit then becomes the last kept digit and the round digit decides the rounding. The selector reports this shift on a flag so that the exponent logic can subtract one. A value of one zero followed by only nines can round up past the shift. That case yields C1 unshifted, a one followed by zeros.

Operands enter on a valid/ready channel and results leave on another. A single output register sits between them. Input is accepted whenever that register is empty or is being drained in the same cycle. While the consumer holds ready low, the result stays frozen and no new input is taken.

Top module: `dec_round_select`

## Requirements
- R1: `in_ready` is high exactly when the output register is empty or `out_ready` is high. An operand accepted on a rising edge (`in_valid` and `in_ready` both high) has its result shown with `out_valid` high from that edge on.
- R2: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all result outputs hold their values.
- R3: The two addend vectors are P BCD digits each (digit i in bits 4i+3..4i, values 0 to 9), and their sum never exceeds 10^P-2. When the sum's top digit is nonzero, the result is the sum or the sum plus one. The guard digit acts as round digit, round-nonzero or sticky acts as sticky, and `out_cls` is 0. Every output digit is 0 to 9.
- R4: When the sum's top digit is zero, the unrounded result is the sum times ten plus the guard digit, with `out_cls` 1. The round digit acts as round digit, sticky as sticky, and a guard digit of 9 carries into the sum.
- R5: When the sum times ten plus guard is 10^P-1 and rounding goes up, the result is 10^(P-1) with `out_cls` 0.
- R6: Mode 0 rounds half to even. It rounds up if the round digit exceeds 5, or equals 5 with the sticky bit set or an odd last kept digit.
- R7: Mode 1 rounds up when the round digit is 5 or more. Mode 2 and the unused codes 5 to 7 truncate.
- R8: Mode 3 rounds a positive value up, and mode 4 a negative value (`in_sign` 1), when the round digit or sticky is nonzero. Otherwise they truncate.
- R9: With `in_ovf` set, `out_inexact` is 1 and `out_cls` is 0. The output is infinity (`out_inf` 1, significand zero) for modes 0 and 1, for mode 3 when positive and for mode 4 when negative. Otherwise it is P nines with `out_inf` 0. Without `in_ovf`, `out_inf` is 0.
- R10: Without overflow, `out_inexact` is set exactly when the effective round digit or sticky bit (per R3/R4) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_sum_a | input | 4*P | First redundant addend, BCD |
| in_sum_b | input | 4*P | Second redundant addend, BCD |
| in_guard | input | 4 | Guard digit |
| in_round | input | 4 | Round digit |
| in_sticky | input | 1 | OR of all lower digits |
| in_sign | input | 1 | Sign, 1 = negative |
| in_mode | input | 3 | Rounding mode code |
| in_ovf | input | 1 | Exponent overflow detected upstream |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_sig | output | 4*P | Rounded significand, BCD |
| out_inf | output | 1 | Result is infinity |
| out_cls | output | 1 | Corrective left shift applied |
| out_inexact | output | 1 | Rounding discarded a nonzero part |

## Verification
Every result is due one clock after its operand is accepted. The bench drives inputs on falling edges, lets the next rising edge capture them, and compares all four result fields at the falling edge after that. During back-pressure it instead compares outputs on each falling edge while `out_ready` is low, then checks the queued operand's result on the falling edge after release. The properties follow the same timing: acceptance on one edge implies the result condition on the next.

// File: rtl/dec_rnd_pkg.sv
package dec_rnd_pkg;
  typedef enum logic [2:0] {
    RM_HALF_EVEN = 3'd0,
    RM_HALF_UP   = 3'd1,
    RM_ZERO      = 3'd2,
    RM_POS       = 3'd3,
    RM_NEG       = 3'd4
  } rmode_e;

  localparam logic [3:0] DIGIT_NINE = 4'd9;
endpackage

// File: rtl/dec_compound_adder.sv
module dec_compound_adder #(
  parameter int P = 7
) (
  input  logic [4*P-1:0] a,
  input  logic [4*P-1:0] b,
  output logic [4*P-1:0] c0,
  output logic [4*P-1:0] c1
);
  // cy0/cy1: carry into digit i for the plain and the incremented chain
  logic [P-1:0] cy0;
  logic [P-1:0] cy1;

  assign cy0[0] = 1'b0;
  assign cy1[0] = 1'b1;

  for (genvar i = 0; i < P; i++) begin : g_dig
    logic [4:0] s0;
    logic [4:0] s1;
    logic       k0;
    logic       k1;
    assign s0 = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'd0, cy0[i]};
    assign s1 = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'd0, cy1[i]};
    assign k0 = (s0 > 5'd9);
    assign k1 = (s1 > 5'd9);
    assign c0[4*i +: 4] = k0 ? 4'(s0 - 5'd10) : s0[3:0];
    assign c1[4*i +: 4] = k1 ? 4'(s1 - 5'd10) : s1[3:0];
    if (i + 1 < P) begin : g_chain
      assign cy0[i+1] = k0;
      assign cy1[i+1] = k1;
    end
  end
endmodule

// File: rtl/dec_round_decide.sv
module dec_round_decide
  import dec_rnd_pkg::*;
(
  input  logic [2:0] mode,
  input  logic [3:0] rdig,
  input  logic       stk,
  input  logic       lsd_odd,
  input  logic       sign,
  output logic       up
);
  logic nonzero;
  assign nonzero = (rdig != 4'd0) || stk;

  always_comb begin
    case (mode)
      RM_HALF_EVEN: up = (rdig > 4'd5) || ((rdig == 4'd5) && (stk || lsd_odd));
      RM_HALF_UP:   up = (rdig >= 4'd5);
      RM_POS:       up = !sign && nonzero;
      RM_NEG:       up = sign && nonzero;
      default:      up = 1'b0;
    endcase
  end
endmodule

// File: rtl/dec_round_select.sv
module dec_round_select
  import dec_rnd_pkg::*;
#(
  parameter int P = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [4*P-1:0] in_sum_a,
  input  logic [4*P-1:0] in_sum_b,
  input  logic [3:0]     in_guard,
  input  logic [3:0]     in_round,
  input  logic           in_sticky,
  input  logic           in_sign,
  input  logic [2:0]     in_mode,
  input  logic           in_ovf,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [4*P-1:0] out_sig,
  output logic           out_inf,
  output logic           out_cls,
  output logic           out_inexact
);
  localparam int W = 4 * P;
  localparam logic [W-1:0] ALL_NINES = {P{DIGIT_NINE}};

  logic [W-1:0] c0, c1;
  logic [3:0]   msd0, msd1;
  logic         need_shift;
  logic [3:0]   rdig;
  logic         stk;
  logic         lsd_odd;
  logic         up;
  logic [3:0]   guard_inc;
  logic         ovf_to_inf;

  logic [W-1:0] nx_sig;
  logic         nx_inf, nx_cls, nx_inexact;
  logic         load;

  dec_compound_adder #(.P(P)) u_add (
    .a  (in_sum_a),
    .b  (in_sum_b),
    .c0 (c0),
    .c1 (c1)
  );

  assign msd0       = c0[W-1 -: 4];
  assign msd1       = c1[W-1 -: 4];
  assign need_shift = (msd0 == 4'd0);

  // effective round digit, sticky and last kept digit after the optional shift
  assign rdig    = need_shift ? in_round : in_guard;
  assign stk     = need_shift ? in_sticky : ((in_round != 4'd0) || in_sticky);
  assign lsd_odd = need_shift ? in_guard[0] : c0[0];

  dec_round_decide u_dec (
    .mode    (in_mode),
    .rdig    (rdig),
    .stk     (stk),
    .lsd_odd (lsd_odd),
    .sign    (in_sign),
    .up      (up)
  );

  assign guard_inc = in_guard + 4'd1;

  always_comb begin
    case (in_mode)
      RM_HALF_EVEN, RM_HALF_UP: ovf_to_inf = 1'b1;
      RM_POS:                   ovf_to_inf = !in_sign;
      RM_NEG:                   ovf_to_inf = in_sign;
      default:                  ovf_to_inf = 1'b0;
    endcase
  end

  always_comb begin
    nx_inf     = 1'b0;
    nx_cls     = 1'b0;
    nx_inexact = (rdig != 4'd0) || stk;
    nx_sig     = c0;
    if (in_ovf) begin
      nx_inf     = ovf_to_inf;
      nx_sig     = ovf_to_inf ? '0 : ALL_NINES;
      nx_inexact = 1'b1;
    end else if (!need_shift) begin
      nx_sig = up ? c1 : c0;
    end else if (!up) begin
      nx_sig = {c0[W-5:0], in_guard};
      nx_cls = 1'b1;
    end else if (in_guard != DIGIT_NINE) begin
      nx_sig = {c0[W-5:0], guard_inc};
      nx_cls = 1'b1;
    end else if (msd1 == 4'd0) begin
      nx_sig = {c1[W-5:0], 4'd0};
      nx_cls = 1'b1;
    end else begin
      // zero followed by nines rounded past the top: take C1 unshifted
      nx_sig = c1;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sig     <= '0;
      out_inf     <= 1'b0;
      out_cls     <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (load) begin
        out_sig     <= nx_sig;
        out_inf     <= nx_inf;
        out_cls     <= nx_cls;
        out_inexact <= nx_inexact;
      end
    end
  end
endmodule

// File: rtl/dec_round_select_chk.sv
module dec_round_select_chk #(
  parameter int P = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [3:0]     in_guard,
  input logic [3:0]     in_round,
  input logic           in_sticky,
  input logic           in_ovf,
  input logic           out_valid,
  input logic           out_ready,
  input logic [4*P-1:0] out_sig,
  input logic           out_inf,
  input logic           out_cls,
  input logic           out_inexact
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r1_accept_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r2_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sig) && $stable(out_inf)
                                   && $stable(out_cls) && $stable(out_inexact)));

  a_r2_no_take_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r9_inf_zero_sig: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inf) |-> (out_sig == '0 && !out_cls));

  a_r9_no_ovf_no_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_ovf) |=> !out_inf);

  a_r9_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_ovf) |=> out_inexact);

  a_r10_exact_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_ovf && in_guard == 4'd0 && in_round == 4'd0 && !in_sticky) |=> !out_inexact);

  always @(posedge clk) begin
    if (rst_n && out_valid) begin
      for (int i = 0; i < P; i++) begin
        a_r3_bcd_digit: assert (out_sig[4*i +: 4] <= 4'd9)
          else $error("R3 output digit %0d out of range", i);
      end
    end
  end
endmodule

bind dec_round_select dec_round_select_chk #(.P(P)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_guard    (in_guard),
  .in_round    (in_round),
  .in_sticky   (in_sticky),
  .in_ovf      (in_ovf),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_sig     (out_sig),
  .out_inf     (out_inf),
  .out_cls     (out_cls),
  .out_inexact (out_inexact)
);

// File: tb/tb_dec_round_select.sv
module tb_dec_round_select;
  localparam int P = 7;
  localparam int W = 4 * P;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [W-1:0]   in_sum_a = '0;
  logic [W-1:0]   in_sum_b = '0;
  logic [3:0]     in_guard = '0;
  logic [3:0]     in_round = '0;
  logic           in_sticky = 1'b0;
  logic           in_sign = 1'b0;
  logic [2:0]     in_mode = '0;
  logic           in_ovf = 1'b0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [W-1:0]   out_sig;
  logic           out_inf;
  logic           out_cls;
  logic           out_inexact;

  int checks = 0;
  int fails  = 0;

  longint unsigned e_sig;
  logic e_inf, e_cls, e_inex;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_round_select #(.P(P)) dut (.*);

  function automatic longint unsigned pow10(int n);
    longint unsigned v = 1;
    for (int i = 0; i < n; i++) v = v * 10;
    return v;
  endfunction

  function automatic logic [W-1:0] to_bcd(longint unsigned v);
    logic [W-1:0] r = '0;
    for (int i = 0; i < P; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic logic want_up(int m, int rd, logic st, logic odd, logic s);
    if (m == 0) return (rd > 5) || (rd == 5 && (st || odd));
    if (m == 1) return rd >= 5;
    if (m == 3) return !s && (rd != 0 || st);
    if (m == 4) return s && (rd != 0 || st);
    return 1'b0;
  endfunction

  task automatic model(longint unsigned sum, int g, int r, logic st, logic s, int m, logic ovf);
    longint unsigned tp = pow10(P);
    longint unsigned base;
    int rd;
    logic sk, up;
    if (ovf) begin
      e_inf  = (m == 0) || (m == 1) || (m == 3 && !s) || (m == 4 && s);
      e_sig  = e_inf ? 0 : tp - 1;
      e_cls  = 1'b0;
      e_inex = 1'b1;
      return;
    end
    e_inf = 1'b0;
    if (sum >= tp / 10) begin
      base = sum; rd = g; sk = (r != 0) || st; e_cls = 1'b0;
    end else begin
      base = sum * 10 + longint'(g); rd = r; sk = st; e_cls = 1'b1;
    end
    up = want_up(m, rd, sk, base[0], s);
    e_sig = base + (up ? 1 : 0);
    if (e_sig == tp) begin
      e_sig = tp / 10;
      e_cls = 1'b0;
    end
    e_inex = (rd != 0) || sk;
  endtask

  task automatic check_out(string tag);
    checks++;
    if (out_sig !== to_bcd(e_sig) || out_inf !== e_inf || out_cls !== e_cls
        || out_inexact !== e_inex || out_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s: actual sig=%h inf=%b cls=%b inex=%b vld=%b expected sig=%h inf=%b cls=%b inex=%b vld=1",
               tag, out_sig, out_inf, out_cls, out_inexact, out_valid,
               to_bcd(e_sig), e_inf, e_cls, e_inex);
    end
  endtask

  task automatic drive(longint unsigned a, longint unsigned b, int g, int r,
                       logic st, logic s, int m, logic ovf);
    in_sum_a  = to_bcd(a);
    in_sum_b  = to_bcd(b);
    in_guard  = 4'(g);
    in_round  = 4'(r);
    in_sticky = st;
    in_sign   = s;
    in_mode   = 3'(m);
    in_ovf    = ovf;
    in_valid  = 1'b1;
  endtask

  task automatic run_one(string tag, longint unsigned a, longint unsigned b, int g, int r,
                         logic st, logic s, int m, logic ovf);
    @(negedge clk);
    drive(a, b, g, r, st, s, m, ovf);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    model(a + b, g, r, st, s, m, ovf);
    check_out(tag);
  endtask

  function automatic longint unsigned rand_below(longint unsigned lim);
    longint unsigned v = {$urandom, $urandom};
    return v % lim;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint unsigned tp = pow10(P);
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual out_valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle: actual ready=%b valid=%b expected 1 0", in_ready, out_valid);
    end

    // directed corners
    run_one("R5 nines carry",      999999, 0,          9, 5, 0, 0, 1, 0);
    run_one("R4 shift guard+1",    123456, 0,          3, 7, 0, 0, 1, 0);
    run_one("R4 shift guard 9",    100000, 23456,      9, 9, 0, 0, 1, 0);
    run_one("R4 shift exact",      123456, 0,          7, 0, 0, 0, 0, 0);
    run_one("R3 redundant add",    5000000, 4999998,   9, 0, 0, 0, 1, 0);
    run_one("R6 tie even",         2000000, 0,         5, 0, 0, 0, 0, 0);
    run_one("R6 tie odd",          1000000, 1000001,   5, 0, 0, 0, 0, 0);
    run_one("R6 tie sticky",       2000000, 0,         5, 0, 1, 0, 0, 0);
    run_one("R6 round digit",      2000000, 0,         5, 1, 0, 0, 0, 0);
    run_one("R7 truncate",         3333333, 0,         9, 9, 1, 0, 2, 0);
    run_one("R7 reserved code",    3333333, 0,         9, 9, 1, 0, 6, 0);
    run_one("R8 up positive",      3333333, 0,         1, 0, 0, 0, 3, 0);
    run_one("R8 up negative",      3333333, 0,         1, 0, 0, 1, 3, 0);
    run_one("R8 down negative",    3333333, 0,         0, 0, 1, 1, 4, 0);
    run_one("R10 exact",           4444444, 0,         0, 0, 0, 0, 1, 0);
    for (int m = 0; m < 5; m++) begin
      run_one("R9 overflow pos", 1234567, 0, 3, 3, 0, 0, m, 1);
      run_one("R9 overflow neg", 1234567, 0, 3, 3, 0, 1, m, 1);
    end

    // back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(2500000, 0, 5, 0, 0, 0, 1, 0);
    @(negedge clk);
    model(2500000, 5, 0, 0, 0, 1, 0);
    check_out("R1 first under stall");
    drive(40000, 2000, 6, 2, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (in_ready !== 1'b0) begin
        fails++;
        $display("FAIL R2 stall ready: actual %b expected 0", in_ready);
      end
      check_out("R2 held result");
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(42000, 6, 2, 0, 0, 0, 0);
    check_out("R1 queued after release");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      longint unsigned s, a;
      int cat = int'($urandom % 4);
      int rr;
      if (cat == 0)      s = rand_below(tp / 10);
      else if (cat == 1) s = tp / 10 - 1;
      else               s = tp / 10 + rand_below(tp - 1 - tp / 10);
      a = rand_below(s + 1);
      rr = ($urandom % 3 == 0) ? 5 : int'($urandom % 10);
      run_one("R3 R4 R6 R7 R8 R10 random", a, s - a, int'($urandom % 10), rr,
              1'($urandom), 1'($urandom), int'($urandom % 8), ($urandom % 16) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule